// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block brings one or two external DDR2 ranks from power-on to an operational state without software involvement. After reset it keeps the clock-enable pin low. It counts out the required stable-clock interval and waits for the PHY to report that its delay-locked loop has locked. It then steps through the fixed DDR2 mode-register program on a small command-request port. That program covers precharge-all, the three extended mode registers, DLL reset, two refreshes, the final mode register write and the OCD default/exit pair. Every minimum wait is counted in clock cycles, and each cycle count is derived at elaboration from the clock-period parameter, rounded up.

Each command is presented with `cmd_valid` and held unchanged until `cmd_ready` is sampled high. The memory-side command generator downstream of this block turns it into pin activity. When the last command of the last rank has been accepted, the block turns on `auto_ref_en` for the refresh engine. In the same cycle it raises `init_complete` as a level and `init_done_pulse` for one cycle.

State machine: `S_WAKE` (power-up wait and lock wait) goes to `S_ISSUE` once the power-up timer has expired and `phy_locked` is high. `S_ISSUE` goes to `S_GAP` when a command that needs a pause afterwards is accepted. `S_GAP` returns to `S_ISSUE` when the gap timer expires. `S_ISSUE` goes to `S_DONE` when the final command is accepted. `S_DONE` is held until reset.

Top module: `ddr2_init_seq`

## Requirements
- R1: While reset is asserted and after its release, `cke`, `cmd_valid`, `auto_ref_en`, `init_done_pulse` and `init_complete` are all low until the first command is presented.
- R2: No command is presented before `phy_locked` has been sampled high on a clock edge.
- R3: The first command appears no earlier than ceil(POWERUP_NS*1000/CLK_PERIOD_PS) cycles after reset release (10000 cycles at the defaults).
- R4: The first command is a NOP. `cke` rises in the cycle the NOP is first presented and stays high until the next reset.
- R5: After the NOP is accepted, the next command is presented no sooner than ceil(400 ns / clock period) cycles later (20 at defaults).
- R6: Type codes are NOP=0, precharge-all=1, mode-register write=2 and refresh=3. For mode-register writes, `cmd_bank` selects the register: 0 = MR, 1 = EMR, 2 = EMR2, 3 = EMR3.
- R6 (continued): Per rank, the order is NOP, precharge-all, EMR2 (addr 0), EMR3 (addr 0), EMR (0x400), MR (0x542), precharge-all, refresh, refresh, MR (0x442), EMR (0x780), EMR (0x400). Non-mode commands carry bank 0 and address 0.
- R7: After the MR write with address 0x442 is accepted, the next command is presented no sooner than MRS_GAP_CYC cycles later (200 at defaults).
- R8: While `cmd_valid` is high and `cmd_ready` is low, the valid signal and all command fields hold. The block advances only after a cycle with both high.
- R9: `cmd_cs` is 0 for the first rank's twelve commands. With NUM_CHIPS=2 the whole twelve-command sequence repeats with `cmd_cs`=1; with NUM_CHIPS=1 no further command follows.
- R10: `auto_ref_en` is low throughout the sequence, rises in the cycle after the last command is accepted, and stays high.
- R11: `init_complete` rises together with `auto_ref_en` and stays high; `init_done_pulse` is high for exactly that first cycle.
- R12: A reset applied in the middle of the sequence returns every output to its R1 state, and the full sequence restarts from the power-up wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phy_locked | input | 1 | PHY DLL lock indication |
| cmd_ready | input | 1 | Downstream accepts the presented command |
| cmd_valid | output | 1 | A command is presented |
| cmd_type | output | 2 | Command code (R6) |
| cmd_cs | output | 1 | Rank index (R9) |
| cmd_bank | output | 3 | Bank / mode-register select |
| cmd_addr | output | ADDR_W | Address / mode-register value |
| cke | output | 1 | Memory clock enable |
| auto_ref_en | output | 1 | Enables the refresh engine |
| init_done_pulse | output | 1 | One-cycle completion strobe |
| init_complete | output | 1 | Completion level |

## Verification
Two events can fall in the same cycle. One is expiry of the power-up interval together with the lock indication: the lock input is raised exactly as the interval runs out, so that both gates clear at once. The other is acceptance of a command together with its first presentation: `cmd_ready` is held permanently high on one instance and randomised on the other. The behavioural model judges both cases. It checks that the first command never precedes a lock sampled on an earlier edge or the power-up count. It also checks that a command accepted in its first cycle still produces the next command, or the required gap, on time with unchanged fields.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

    typedef enum logic [1:0] {
        CMD_NOP  = 2'd0,
        CMD_PALL = 2'd1,
        CMD_MODE = 2'd2,
        CMD_REF  = 2'd3
    } cmd_kind_e;

    typedef enum logic [1:0] {
        GAP_NONE = 2'd0,
        GAP_CKE  = 2'd1,
        GAP_MRS  = 2'd2
    } gap_kind_e;

    localparam int MODE_VAL_W     = 11;
    localparam int STEPS_PER_RANK = 12;

    typedef struct packed {
        cmd_kind_e              kind;
        logic [2:0]             bank;
        logic [MODE_VAL_W-1:0]  value;
        gap_kind_e              gap;
    } init_cmd_t;

endpackage

// File: rtl/ddr2_init_timer.sv
module ddr2_init_timer #(
    parameter int               CNT_W   = 14,
    parameter logic [CNT_W-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= RST_VAL;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/ddr2_init_cmdrom.sv
module ddr2_init_cmdrom
    import ddr2_init_pkg::*;
#(
    parameter int NUM_CHIPS = 2,
    parameter int IDX_W     = 5
) (
    input  logic [IDX_W-1:0] step,
    output init_cmd_t        cmd,
    output logic             chip
);

    logic [IDX_W-1:0] local_step;

    generate
        if (NUM_CHIPS == 2) begin : g_two
            assign chip       = (step >= IDX_W'(STEPS_PER_RANK));
            assign local_step = chip ? step - IDX_W'(STEPS_PER_RANK) : step;
        end else begin : g_one
            assign chip       = 1'b0;
            assign local_step = step;
        end
    endgenerate

    always_comb begin
        cmd = '{kind: CMD_NOP, bank: 3'd0, value: '0, gap: GAP_NONE};
        unique case (local_step)
            IDX_W'(0):  cmd = '{kind: CMD_NOP,  bank: 3'd0, value: 11'h000, gap: GAP_CKE};
            IDX_W'(1):  cmd = '{kind: CMD_PALL, bank: 3'd0, value: 11'h000, gap: GAP_NONE};
            IDX_W'(2):  cmd = '{kind: CMD_MODE, bank: 3'd2, value: 11'h000, gap: GAP_NONE};
            IDX_W'(3):  cmd = '{kind: CMD_MODE, bank: 3'd3, value: 11'h000, gap: GAP_NONE};
            IDX_W'(4):  cmd = '{kind: CMD_MODE, bank: 3'd1, value: 11'h400, gap: GAP_NONE};
            IDX_W'(5):  cmd = '{kind: CMD_MODE, bank: 3'd0, value: 11'h542, gap: GAP_NONE};
            IDX_W'(6):  cmd = '{kind: CMD_PALL, bank: 3'd0, value: 11'h000, gap: GAP_NONE};
            IDX_W'(7):  cmd = '{kind: CMD_REF,  bank: 3'd0, value: 11'h000, gap: GAP_NONE};
            IDX_W'(8):  cmd = '{kind: CMD_REF,  bank: 3'd0, value: 11'h000, gap: GAP_NONE};
            IDX_W'(9):  cmd = '{kind: CMD_MODE, bank: 3'd0, value: 11'h442, gap: GAP_MRS};
            IDX_W'(10): cmd = '{kind: CMD_MODE, bank: 3'd1, value: 11'h780, gap: GAP_NONE};
            IDX_W'(11): cmd = '{kind: CMD_MODE, bank: 3'd1, value: 11'h400, gap: GAP_NONE};
            default:    cmd = '{kind: CMD_NOP,  bank: 3'd0, value: 11'h000, gap: GAP_NONE};
        endcase
    end

endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
    import ddr2_init_pkg::*;
#(
    parameter int NUM_CHIPS     = 2,
    parameter int CLK_PERIOD_PS = 20000,
    parameter int POWERUP_NS    = 200000,
    parameter int CKE_WAIT_NS   = 400,
    parameter int MRS_GAP_CYC   = 200,
    parameter int ADDR_W        = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phy_locked,
    input  logic              cmd_ready,
    output logic              cmd_valid,
    output logic [1:0]        cmd_type,
    output logic              cmd_cs,
    output logic [2:0]        cmd_bank,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              cke,
    output logic              auto_ref_en,
    output logic              init_done_pulse,
    output logic              init_complete
);

    localparam int PWRUP_CYC = (POWERUP_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
    localparam int CKE_CYC   = (CKE_WAIT_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
    localparam int MAX_A     = (PWRUP_CYC > CKE_CYC) ? PWRUP_CYC : CKE_CYC;
    localparam int MAX_CYC   = (MAX_A > MRS_GAP_CYC) ? MAX_A : MRS_GAP_CYC;
    localparam int CNT_W     = $clog2(MAX_CYC + 1);
    localparam int TOTAL     = STEPS_PER_RANK * NUM_CHIPS;
    localparam int IDX_W     = $clog2(TOTAL);

    typedef enum logic [1:0] {
        S_WAKE  = 2'd0,
        S_ISSUE = 2'd1,
        S_GAP   = 2'd2,
        S_DONE  = 2'd3
    } state_e;

    state_e           state_q, state_n;
    logic [IDX_W-1:0] step_q;
    init_cmd_t        cur;
    logic             cur_chip;
    logic             last_step;
    logic             accept;
    logic             t_zero;
    logic             t_load;
    logic [CNT_W-1:0] t_val;
    logic             cke_q, ref_q, pulse_q;

    ddr2_init_cmdrom #(
        .NUM_CHIPS (NUM_CHIPS),
        .IDX_W     (IDX_W)
    ) u_rom (
        .step (step_q),
        .cmd  (cur),
        .chip (cur_chip)
    );

    ddr2_init_timer #(
        .CNT_W   (CNT_W),
        .RST_VAL (CNT_W'(PWRUP_CYC))
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .zero     (t_zero)
    );

    assign last_step = (step_q == IDX_W'(TOTAL - 1));
    assign accept    = (state_q == S_ISSUE) && cmd_ready;
    assign t_load    = accept && (cur.gap != GAP_NONE);
    assign t_val     = (cur.gap == GAP_CKE) ? CNT_W'(CKE_CYC) : CNT_W'(MRS_GAP_CYC);

    // next-state decision
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            S_WAKE:  if (t_zero && phy_locked) state_n = S_ISSUE;
            S_ISSUE: begin
                if (cmd_ready) begin
                    if (last_step)               state_n = S_DONE;
                    else if (cur.gap != GAP_NONE) state_n = S_GAP;
                end
            end
            S_GAP:   if (t_zero) state_n = S_ISSUE;
            S_DONE:  state_n = S_DONE;
            default: state_n = S_WAKE;
        endcase
    end

    // state register and step index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_WAKE;
            step_q  <= '0;
        end else begin
            state_q <= state_n;
            if (accept && !last_step) step_q <= step_q + 1'b1;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cke_q   <= 1'b0;
            ref_q   <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            cke_q   <= cke_q || (state_n == S_ISSUE);
            ref_q   <= (state_n == S_DONE);
            pulse_q <= (state_q == S_ISSUE) && (state_n == S_DONE);
        end
    end

    assign cmd_valid       = (state_q == S_ISSUE);
    assign cmd_type        = cur.kind;
    assign cmd_cs          = cur_chip;
    assign cmd_bank        = cur.bank;
    assign cmd_addr        = {{(ADDR_W - MODE_VAL_W){1'b0}}, cur.value};
    assign cke             = cke_q;
    assign auto_ref_en     = ref_q;
    assign init_done_pulse = pulse_q;
    assign init_complete   = ref_q;

    a_r2_no_cmd_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAKE && !phy_locked) |=> !cmd_valid);

    a_r4_cke_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cke |=> cke);

    a_r4_cke_with_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> cke);

    a_r8_hold_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_type) && $stable(cmd_cs)
                                       && $stable(cmd_bank) && $stable(cmd_addr)));

    a_r10_no_refresh_mid: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !auto_ref_en);

    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        init_done_pulse |=> (!init_done_pulse && init_complete));

endmodule

// File: tb/ddr2_init_seq_tb.sv
module ddr2_init_mon #(
    parameter int CHIPS = 2,
    parameter int PWR   = 10000,
    parameter int W_CKE = 20,
    parameter int W_MRS = 200
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        locked,
    input  logic        ready,
    input  logic        valid,
    input  logic [1:0]  ctype,
    input  logic        cs,
    input  logic [2:0]  bank,
    input  logic [13:0] addr,
    input  logic        cke,
    input  logic        ref_en,
    input  logic        pulse,
    input  logic        complete,
    output int          checks,
    output int          fails
);
    int n_chk = 0;
    int n_bad = 0;
    assign checks = n_chk;
    assign fails  = n_bad;

    int  cyc, idx, acc_cyc, gap_need, fin_cyc;
    bit  started, fin_set, lock_prev, hold;
    int  h_type, h_cs, h_bank, h_addr;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s (%m) actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic exp_cmd(input int s, output int k, output int b, output int a);
        k = 2; b = 0; a = 0;
        case (s)
            0:  k = 0;
            1:  k = 1;
            2:  b = 2;
            3:  b = 3;
            4:  begin b = 1; a = 'h400; end
            5:  a = 'h542;
            6:  k = 1;
            7:  k = 3;
            8:  k = 3;
            9:  a = 'h442;
            10: begin b = 1; a = 'h780; end
            default: begin b = 1; a = 'h400; end
        endcase
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            cyc = 0; idx = 0; gap_need = 0; acc_cyc = 0; fin_cyc = 0;
            started = 0; fin_set = 0; hold = 0;
            chk(!cke && !valid && !ref_en && !pulse && !complete, "R1/R12 reset outputs",
                {cke, valid, ref_en, pulse, complete}, 0);
        end else begin
            cyc++;
            if (valid && !started) begin
                started = 1;
                chk(cyc > PWR, "R3 power-up wait", cyc, PWR + 1);
                chk(lock_prev, "R2 lock before first command", lock_prev, 1);
            end
            chk(cke == started, "R1/R4 cke level", cke, started);
            if (valid) begin
                chk(!fin_set, "R9 no command after completion", idx, CHIPS * 12);
                if (hold)
                    chk(ctype == h_type && cs == h_cs && bank == h_bank && addr == h_addr,
                        "R8 fields held", {ctype, cs, bank, addr}, {h_type[1:0], h_cs[0], h_bank[2:0], h_addr[13:0]});
                if (gap_need != 0 && cyc > acc_cyc) begin
                    chk(cyc - acc_cyc > gap_need, (gap_need == W_CKE) ? "R5 gap after NOP" : "R7 gap after MR 0x442",
                        cyc - acc_cyc, gap_need + 1);
                    gap_need = 0;
                end
                if (ready) begin
                    int k, b, a;
                    exp_cmd(idx % 12, k, b, a);
                    chk(ctype == k && bank == b && addr == a, "R6 command content", {ctype, bank, addr}, {k[1:0], b[2:0], a[13:0]});
                    chk(cs == (idx / 12), "R9 rank select", cs, idx / 12);
                    if (idx % 12 == 0) gap_need = W_CKE;
                    if (idx % 12 == 9) gap_need = W_MRS;
                    acc_cyc = cyc;
                    hold = 0;
                    idx++;
                    if (idx == CHIPS * 12) begin fin_set = 1; fin_cyc = cyc; end
                end else begin
                    hold = 1; h_type = ctype; h_cs = cs; h_bank = bank; h_addr = addr;
                end
            end else begin
                chk(!hold, "R8 valid dropped before ready", 0, 1);
                hold = 0;
            end
            chk(ref_en == (fin_set && cyc > fin_cyc), "R10 refresh enable", ref_en, fin_set && cyc > fin_cyc);
            chk(complete == (fin_set && cyc > fin_cyc), "R11 complete level", complete, fin_set && cyc > fin_cyc);
            chk(pulse == (fin_set && cyc == fin_cyc + 1), "R11 done pulse", pulse, fin_set && cyc == fin_cyc + 1);
        end
        lock_prev = locked;
    end
endmodule

module ddr2_init_seq_tb;
    localparam int PWR = (200000 * 1000 + 20000 - 1) / 20000;

    logic clk = 0;
    always #10 clk = ~clk;

    logic rst_a = 0, lock_a = 0, rdy_a = 0;
    logic rst_b = 0, lock_b = 0, rdy_b = 1;

    logic        v_a, cs_a, cke_a, ref_a, pl_a, cp_a;
    logic [1:0]  t_a;
    logic [2:0]  b_a;
    logic [13:0] ad_a;
    logic        v_b, cs_b, cke_b, ref_b, pl_b, cp_b;
    logic [1:0]  t_b;
    logic [2:0]  b_b;
    logic [13:0] ad_b;
    int ca, fa, cb, fb;
    int own_chk = 0, own_bad = 0;

    ddr2_init_seq #(.NUM_CHIPS(2)) u_dut (
        .clk(clk), .rst_n(rst_a), .phy_locked(lock_a), .cmd_ready(rdy_a),
        .cmd_valid(v_a), .cmd_type(t_a), .cmd_cs(cs_a), .cmd_bank(b_a), .cmd_addr(ad_a),
        .cke(cke_a), .auto_ref_en(ref_a), .init_done_pulse(pl_a), .init_complete(cp_a));

    ddr2_init_seq #(.NUM_CHIPS(1)) u_dut_b (
        .clk(clk), .rst_n(rst_b), .phy_locked(lock_b), .cmd_ready(rdy_b),
        .cmd_valid(v_b), .cmd_type(t_b), .cmd_cs(cs_b), .cmd_bank(b_b), .cmd_addr(ad_b),
        .cke(cke_b), .auto_ref_en(ref_b), .init_done_pulse(pl_b), .init_complete(cp_b));

    ddr2_init_mon #(.CHIPS(2), .PWR(PWR)) u_mon_a (
        .clk(clk), .rst_n(rst_a), .locked(lock_a), .ready(rdy_a), .valid(v_a), .ctype(t_a),
        .cs(cs_a), .bank(b_a), .addr(ad_a), .cke(cke_a), .ref_en(ref_a), .pulse(pl_a),
        .complete(cp_a), .checks(ca), .fails(fa));

    ddr2_init_mon #(.CHIPS(1), .PWR(PWR)) u_mon_b (
        .clk(clk), .rst_n(rst_b), .locked(lock_b), .ready(rdy_b), .valid(v_b), .ctype(t_b),
        .cs(cs_b), .bank(b_b), .addr(ad_b), .cke(cke_b), .ref_en(ref_b), .pulse(pl_b),
        .complete(cp_b), .checks(cb), .fails(fb));

    bit rand_ready = 1;
    always @(posedge clk) begin
        #2;
        if (rand_ready) rdy_a = ($urandom % 3) != 0;
    end

    task automatic report();
        $display("  test done: total=%0d bad=%0d", ca + cb + own_chk, fa + fb + own_bad);
        $finish;
    endtask

    task automatic own(input bit ok, input string req, input int act, input int exp);
        own_chk++;
        if (!ok) begin
            own_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    initial begin
        fork
            begin
                // instance A: early lock, random ready, mid-sequence reset (R12)
                repeat (4) @(posedge clk);
                #2 rst_a = 1;
                repeat (100) @(posedge clk);
                #2 lock_a = 1;
                repeat (PWR + 40) @(posedge clk);
                own(cke_a, "R4 cke high mid-sequence", cke_a, 1);
                #2 rst_a = 0; lock_a = 0;
                repeat (3) @(posedge clk);
                #2 rst_a = 1;
                // lock rises exactly as the power-up interval runs out
                repeat (PWR - 1) @(posedge clk);
                #2 lock_a = 1;
                while (!cp_a) @(posedge clk);
                repeat (5) @(posedge clk);
                own(cp_a && ref_a, "R10 A complete at end", cp_a, 1);
            end
            begin
                // instance B: single rank, ready always high, late lock (R2)
                repeat (4) @(posedge clk);
                #2 rst_b = 1;
                repeat (PWR + 50) @(posedge clk);
                #12;
                own(!v_b && !cke_b, "R2 held off without lock", v_b, 0);
                @(posedge clk);
                #2 lock_b = 1;
                while (!cp_b) @(posedge clk);
                repeat (300) @(posedge clk);
                own(cp_b && !v_b, "R9 single rank ends after twelve", v_b, 0);
            end
        join
        report();
    end

    initial begin
        repeat (150000) @(posedge clk);
        own(0, "watchdog expired", 0, 1);
        report();
    end
endmodule